// File: doc/BRIEF.md
# Infrared SIR Pulse Codec

This block sits between a UART core and an infrared transceiver. On the transmit side it turns the core's NRZ bit stream into short light pulses. A zero bit gives one pulse at the start of its bit window, and a one bit gives no pulse. On the receive side it turns the pulses it detects back into an NRZ level for the core. Timing comes from a 16x baud enable tick, which the divisor logic elsewhere in the UART supplies. A second, independent reference tick sets a fixed pulse width for a low-power mode that does not depend on the baud rate.

When the infrared path is active, the block keeps the plain wired UART path quiet. The wired transmit pin marks high. The wired receive pin and the modem status inputs are masked from the core. When the infrared path is inactive, the wired path passes straight through and the infrared output stays dark. A test loopback routes the block's own encoder output back into its decoder. It also lifts the rule that the receiver is deaf while the encoder transmits.

Top module: `sir_codec`

## Requirements
- R1: During and right after a synchronous reset, `ir_tx` is 0, `txd_pin` is 1, `rxd_core` is 1 and every bit of `modem_core` is 1.
- R2: With the infrared path active and `lp_mode` 0, a zero on `uart_tx_bit` at the first `baud16_tick` of a bit window sets `ir_tx` to 1 in the next cycle, and `ir_tx` stays 1 for exactly 3 tick periods. The next bit window starts 16 ticks after that first tick. A one bit leaves `ir_tx` at 0 for the whole window.
- R3: With `lp_mode` 1, the pulse starts at the same point as in R2 and ends at the third `lp_tick` strictly after its start, whatever the baud tick rate.
- R4: The infrared path is active only when both `uart_en` and `sir_en` are 1. While it is inactive:
  - `ir_tx` drops to 0 within one cycle.
  - `ir_rx_n` has no effect.
  - One cycle later, `txd_pin` equals `uart_tx_bit`, `rxd_core` equals `plain_rxd` and `modem_core` equals `modem_pin`.
- R5: While the infrared path is active, `txd_pin` is 1 and `modem_core` is all ones from the next cycle on. `plain_rxd` and `modem_pin` have no effect.
- R6: While the infrared path is active, `ir_rx_n` is active low: 0 means light. When light is seen at two consecutive `baud16_tick`s, `rxd_core` goes to 0 and is held there for 16 ticks, which is one bit period. Otherwise `rxd_core` is 1.
- R7: A received pulse that is seen at only one `baud16_tick` is discarded as a glitch, and `rxd_core` stays 1. Any pulse shorter than one tick period falls in this case.
- R8: Outside loopback, the decoder ignores `ir_rx_n` during any bit window in which the encoder is sending a zero.
- R9: Loopback is active only when `uart_en`, `sir_en`, `loop_en` and `sir_test` are all 1. In loopback, `ir_rx_n` is ignored and the inverted encoder output drives the decoder input, so the bit sent in each window appears on `rxd_core` by the middle of that window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud16_tick | input | 1 | One-cycle enable at 16 times the bit rate |
| lp_tick | input | 1 | One-cycle low-power reference enable |
| uart_en | input | 1 | Global UART enable |
| sir_en | input | 1 | Selects the infrared path (only while `uart_en` is 1) |
| lp_mode | input | 1 | 1 selects the fixed low-power pulse width |
| loop_en | input | 1 | Loopback request |
| sir_test | input | 1 | Test override; needed together with `loop_en` for loopback |
| uart_tx_bit | input | 1 | NRZ transmit bit from the UART core |
| plain_rxd | input | 1 | Wired receive pin |
| modem_pin | input | MODEM_W | Wired modem status inputs |
| ir_rx_n | input | 1 | Infrared receiver output, low while light is present |
| ir_tx | output | 1 | Infrared emitter drive, high during a light pulse |
| txd_pin | output | 1 | Wired transmit pin |
| rxd_core | output | 1 | NRZ receive bit to the UART core |
| modem_core | output | MODEM_W | Modem status presented to the core |

## Verification
The encoder keeps a bit-window phase counter. If that counter slips, the pulse moves away from the first tick of the window, or its width changes from 12 cycles. The bench sees this in the very first zero bit it sends. A decoder state error shows up in two ways. An accept flag that is not cleared, or a hold counter that is off by one, makes `rxd_core` read wrong at the middle of a bit window. A hold that does not end leaks a zero into the following one bit. Either case is visible within two bit windows. A wrong mode decode shows up one cycle after the enables change: the wired pins pass through when they should be masked, or are masked when they should pass through.

// File: rtl/sir_pkg.sv
package sir_pkg;

  typedef struct packed {
    logic active;     // infrared path selected and UART enabled
    logic loopback;   // encoder output routed into decoder
    logic low_power;  // fixed-width pulse mode
  } sir_cfg_t;

  function automatic sir_cfg_t decode_cfg(input logic uart_en, input logic sir_en,
                                          input logic lp_mode, input logic loop_en,
                                          input logic sir_test);
    sir_cfg_t c;
    c.active    = uart_en & sir_en;
    c.loopback  = uart_en & sir_en & loop_en & sir_test;
    c.low_power = lp_mode;
    return c;
  endfunction

endpackage

// File: rtl/sir_encoder.sv
module sir_encoder #(
  parameter int TICKS_PER_BIT = 16,
  parameter int PULSE_TICKS   = 3,
  parameter int LP_TICKS      = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic lp_tick,
  input  logic active,
  input  logic low_power,
  input  logic tx_bit,
  output logic pulse,
  output logic busy
);
  localparam int PW = $clog2(TICKS_PER_BIT);
  localparam int LW = $clog2(LP_TICKS + 1);
  localparam logic [PW-1:0] PH_LAST = PW'(TICKS_PER_BIT - 1);
  localparam logic [PW-1:0] PH_OFF  = PW'(PULSE_TICKS);
  localparam logic [LW-1:0] LP_LAST = LW'(LP_TICKS - 1);

  logic [PW-1:0] ph;
  logic [LW-1:0] lp_cnt;
  logic          lp_q;
  logic          window_start;

  assign window_start = tick && (!busy || ph == '0);

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      pulse  <= 1'b0;
      busy   <= 1'b0;
      ph     <= '0;
      lp_cnt <= '0;
      lp_q   <= 1'b0;
    end else if (window_start) begin
      if (!tx_bit) begin
        busy   <= 1'b1;
        ph     <= PW'(1);
        pulse  <= 1'b1;
        lp_q   <= low_power;
        lp_cnt <= '0;
      end else begin
        busy  <= 1'b0;
        ph    <= '0;
        pulse <= 1'b0;
      end
    end else begin
      if (tick && busy) ph <= (ph == PH_LAST) ? '0 : ph + 1'b1;
      if (pulse && !lp_q && tick && busy && ph == PH_OFF) pulse <= 1'b0;
      if (pulse && lp_q && lp_tick) begin
        if (lp_cnt == LP_LAST) pulse <= 1'b0;
        else lp_cnt <= lp_cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/sir_decoder.sv
module sir_decoder #(
  parameter int TICKS_PER_BIT = 16,
  parameter int SYNC_STAGES   = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic active,
  input  logic loopback,
  input  logic enc_pulse,
  input  logic enc_busy,
  input  logic ir_rx_n,
  output logic zero_hold
);
  localparam int HW = $clog2(TICKS_PER_BIT);
  localparam logic [HW-1:0] H_LAST = HW'(TICKS_PER_BIT - 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   src_n;
  logic                   light;
  logic                   seen;
  logic                   taken;
  logic                   accept;
  logic [HW-1:0]          hcnt;

  // test loopback: emitter drive inverted into the active-low receive path
  assign src_n = loopback ? ~enc_pulse : ir_rx_n;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '1;
    else     sync_q <= {sync_q[SYNC_STAGES-2:0], src_n};
  end

  // half duplex: deaf while own zero bit is on air, unless looped back
  assign light  = ~sync_q[SYNC_STAGES-1] && (loopback || !enc_busy);
  assign accept = light && seen && !taken;

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      seen      <= 1'b0;
      taken     <= 1'b0;
      zero_hold <= 1'b0;
      hcnt      <= '0;
    end else if (tick) begin
      seen  <= light;
      taken <= light && (taken || seen);
      if (accept) begin
        zero_hold <= 1'b1;
        hcnt      <= '0;
      end else if (zero_hold) begin
        if (hcnt == H_LAST) zero_hold <= 1'b0;
        else hcnt <= hcnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/sir_codec.sv
module sir_codec
  import sir_pkg::*;
#(
  parameter int TICKS_PER_BIT = 16,
  parameter int PULSE_TICKS   = 3,
  parameter int LP_TICKS      = 3,
  parameter int SYNC_STAGES   = 2,
  parameter int MODEM_W       = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               baud16_tick,
  input  logic               lp_tick,
  input  logic               uart_en,
  input  logic               sir_en,
  input  logic               lp_mode,
  input  logic               loop_en,
  input  logic               sir_test,
  input  logic               uart_tx_bit,
  input  logic               plain_rxd,
  input  logic [MODEM_W-1:0] modem_pin,
  input  logic               ir_rx_n,
  output logic               ir_tx,
  output logic               txd_pin,
  output logic               rxd_core,
  output logic [MODEM_W-1:0] modem_core
);
  sir_cfg_t cfg;
  logic     enc_pulse;
  logic     enc_busy;
  logic     zero_hold;

  assign cfg = decode_cfg(uart_en, sir_en, lp_mode, loop_en, sir_test);

  sir_encoder #(
    .TICKS_PER_BIT(TICKS_PER_BIT),
    .PULSE_TICKS  (PULSE_TICKS),
    .LP_TICKS     (LP_TICKS)
  ) u_enc (
    .clk      (clk),
    .rst      (rst),
    .tick     (baud16_tick),
    .lp_tick  (lp_tick),
    .active   (cfg.active),
    .low_power(cfg.low_power),
    .tx_bit   (uart_tx_bit),
    .pulse    (enc_pulse),
    .busy     (enc_busy)
  );

  sir_decoder #(
    .TICKS_PER_BIT(TICKS_PER_BIT),
    .SYNC_STAGES  (SYNC_STAGES)
  ) u_dec (
    .clk      (clk),
    .rst      (rst),
    .tick     (baud16_tick),
    .active   (cfg.active),
    .loopback (cfg.loopback),
    .enc_pulse(enc_pulse),
    .enc_busy (enc_busy),
    .ir_rx_n  (ir_rx_n),
    .zero_hold(zero_hold)
  );

  assign ir_tx = enc_pulse;

  always_ff @(posedge clk) begin
    if (rst) begin
      txd_pin    <= 1'b1;
      rxd_core   <= 1'b1;
      modem_core <= '1;
    end else begin
      txd_pin    <= cfg.active ? 1'b1 : uart_tx_bit;
      rxd_core   <= cfg.active ? ~zero_hold : plain_rxd;
      modem_core <= cfg.active ? {MODEM_W{1'b1}} : modem_pin;
    end
  end

endmodule

// File: rtl/sir_codec_chk.sv
module sir_codec_chk #(
  parameter int PULSE_TICKS = 3,
  parameter int MODEM_W     = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               baud16_tick,
  input logic               uart_en,
  input logic               sir_en,
  input logic               lp_mode,
  input logic               uart_tx_bit,
  input logic               plain_rxd,
  input logic               ir_tx,
  input logic               txd_pin,
  input logic               rxd_core,
  input logic [MODEM_W-1:0] modem_core
);
  localparam int CW = $clog2(PULSE_TICKS + 1) + 1;

  logic [CW-1:0] tk_cnt;

  // ticks seen while the emitter is lit in normal-width mode
  always_ff @(posedge clk) begin
    if (rst || !ir_tx) tk_cnt <= '0;
    else if (baud16_tick && !lp_mode) tk_cnt <= tk_cnt + 1'b1;
  end

  AST_PULSE_START: assert property (@(posedge clk) disable iff (rst)
    $rose(ir_tx) |-> ($past(baud16_tick) && !$past(uart_tx_bit) && $past(uart_en && sir_en))); // R2
  AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (rst)
    (ir_tx && !lp_mode) |-> (tk_cnt < CW'(PULSE_TICKS))); // R2
  AST_DARK_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    !(uart_en && sir_en) |=> !ir_tx); // R4
  AST_PLAIN_RX_PASS: assert property (@(posedge clk) disable iff (rst)
    !(uart_en && sir_en) |=> (rxd_core == $past(plain_rxd))); // R4
  AST_TXD_MARKING: assert property (@(posedge clk) disable iff (rst)
    (uart_en && sir_en) |=> txd_pin); // R5
  AST_MODEM_MASKED: assert property (@(posedge clk) disable iff (rst)
    (uart_en && sir_en) |=> (modem_core == {MODEM_W{1'b1}})); // R5

endmodule

bind sir_codec sir_codec_chk #(.PULSE_TICKS(PULSE_TICKS), .MODEM_W(MODEM_W)) u_chk (.*);

// File: tb/sim_sir_codec.sv
module sim_sir_codec;
  localparam int TPB     = 16;  // ticks per bit
  localparam int TP      = 4;   // cycles per baud16 tick
  localparam int BIT_CYC = TPB * TP;
  localparam int PULSE   = 3;
  localparam int LPT     = 3;

  logic clk = 0, rst = 1, baud16_tick = 0, lp_tick = 0;
  logic uart_en = 0, sir_en = 0, lp_mode = 0, loop_en = 0, sir_test = 0;
  logic uart_tx_bit = 1, plain_rxd = 1, ir_rx_n = 1;
  logic [3:0] modem_pin = 4'h0;
  logic ir_tx, txd_pin, rxd_core;
  logic [3:0] modem_core;

  int errs = 0, checks = 0, lp_period = 0, lp_phase = 0;
  bit done = 0;
  logic s_ir, s_rxd, s_txd, last_txs;
  logic [3:0] s_modem;

  sir_codec u0 (.clk(clk), .rst(rst), .baud16_tick(baud16_tick), .lp_tick(lp_tick),
    .uart_en(uart_en), .sir_en(sir_en), .lp_mode(lp_mode), .loop_en(loop_en),
    .sir_test(sir_test), .uart_tx_bit(uart_tx_bit), .plain_rxd(plain_rxd),
    .modem_pin(modem_pin), .ir_rx_n(ir_rx_n), .ir_tx(ir_tx), .txd_pin(txd_pin),
    .rxd_core(rxd_core), .modem_core(modem_core));

  always #4 clk = ~clk;  // 125 MHz

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // sample outputs of the last edge, then drive the next cycle's inputs
  task automatic step(input bit tk);
    @(negedge clk);
    s_ir = ir_tx; s_rxd = rxd_core; s_txd = txd_pin; s_modem = modem_core;
    baud16_tick = tk;
    if (lp_period > 0) begin
      lp_tick = (lp_phase == 0);
      lp_phase = (lp_phase + 1) % lp_period;
    end else lp_tick = 0;
  endtask

  // expected count of lit cycles in one bit window
  function automatic int lit_lo(input bit b, input bit on, input bit lp, input int lpp);
    if (!on || b) return 0;
    if (!lp) return PULSE * TP;
    return (LPT - 1) * lpp + 1;
  endfunction
  function automatic int lit_hi(input bit b, input bit on, input bit lp, input int lpp);
    if (!on || b) return 0;
    if (!lp) return PULSE * TP;
    return LPT * lpp;
  endfunction

  task automatic run_bit(input bit b, input int pat, input int plen, input int lo,
                         input int hi, input int rx_exp, input string req);
    int lit; bit first; bit rxm;
    lit = 0; first = 0; rxm = 1;
    for (int k = 0; k < BIT_CYC; k++) begin
      step((k % TP) == 0);
      if (k == 0) uart_tx_bit = b;
      ir_rx_n = !(pat >= 0 && k >= pat && k < pat + plen);
      if (k > 0 && s_ir) lit++;
      if (k == 1) first = s_ir;
      if (k == 2) last_txs = s_txd;
      if (k == 40) rxm = s_rxd;
    end
    ir_rx_n = 1;
    chk(lit >= lo && lit <= hi, req, lit, lo);
    if (lo > 0) chk(first == 1, req, first, 1);
    if (rx_exp >= 0) chk(rxm == rx_exp[0], req, rxm, rx_exp);
  endtask

  initial begin
    int unsigned sd;
    sd = $urandom(32'd4711);
    repeat (3) step(0);
    chk(s_ir == 0, "R1", s_ir, 0);
    chk(s_txd == 1, "R1", s_txd, 1);
    chk(s_rxd == 1, "R1", s_rxd, 1);
    chk(s_modem == 4'hF, "R1", s_modem, 15);
    rst = 0;

    // wired path with infrared off
    uart_en = 1; modem_pin = 4'h5; plain_rxd = 0;
    repeat (4) step(0);
    chk(s_rxd == 0, "R4", s_rxd, 0);
    chk(s_modem == 4'h5, "R4", s_modem, 5);
    run_bit(0, 4, 12, 0, 0, 0, "R4");
    chk(last_txs == 0, "R4", last_txs, 0);
    run_bit(1, 4, 12, 0, 0, 0, "R4");
    chk(last_txs == 1, "R4", last_txs, 1);
    // infrared requested but UART disabled
    uart_en = 0; sir_en = 1; plain_rxd = 1;
    run_bit(0, 4, 12, 0, 0, 1, "R4");
    chk(last_txs == 0, "R4", last_txs, 0);

    // infrared active, normal width, no loopback
    uart_en = 1; plain_rxd = 0; modem_pin = 4'h0;
    repeat (4) step(0);
    chk(s_modem == 4'hF, "R5", s_modem, 15);
    foreach (sd_bits_dummy[i]) ;
    begin
      bit pat_bits [5] = '{1, 0, 0, 1, 0};
      foreach (pat_bits[i]) begin
        run_bit(pat_bits[i], pat_bits[i] ? -1 : 4, 12, lit_lo(pat_bits[i], 1, 0, 0),
                lit_hi(pat_bits[i], 1, 0, 0), 1, "R2/R8");
        chk(last_txs == 1, "R5", last_txs, 1);
      end
    end

    // glitch and genuine pulses from outside while encoder idle
    run_bit(1, 3, 2, 0, 0, 1, "R7");
    run_bit(1, -1, 0, 0, 0, 1, "R7");
    run_bit(1, 2, 12, 0, 0, 0, "R6");
    run_bit(1, -1, 0, 0, 0, 1, "R6");

    // loopback, external pulses must be ignored
    loop_en = 1; sir_test = 1;
    begin
      bit lb_bits [6] = '{0, 1, 1, 0, 0, 1};
      foreach (lb_bits[i])
        run_bit(lb_bits[i], lb_bits[i] ? 20 : -1, 12, lit_lo(lb_bits[i], 1, 0, 0),
                lit_hi(lb_bits[i], 1, 0, 0), lb_bits[i], "R9");
    end
    sir_test = 0;
    run_bit(0, -1, 0, PULSE * TP, PULSE * TP, 1, "R9");
    run_bit(1, -1, 0, 0, 0, 1, "R9");

    // low-power width
    sir_test = 1; lp_mode = 1; lp_period = 1; lp_phase = 0;
    run_bit(0, -1, 0, lit_lo(0, 1, 1, 1), lit_hi(0, 1, 1, 1), 1, "R3/R7");
    run_bit(1, -1, 0, 0, 0, 1, "R3");
    lp_period = 5; lp_phase = 0;
    begin
      bit lp_bits [5] = '{0, 1, 0, 0, 1};
      foreach (lp_bits[i])
        run_bit(lp_bits[i], -1, 0, lit_lo(lp_bits[i], 1, 1, 5),
                lit_hi(lp_bits[i], 1, 1, 5), lp_bits[i], "R3");
    end

    // random bit streams in loopback, both width modes
    for (int seg = 0; seg < 4; seg++) begin
      lp_mode = seg[0]; lp_period = seg[0] ? 5 : 0; lp_phase = 0;
      for (int n = 0; n < 12; n++) begin
        bit b;
        b = 1'($urandom % 2);
        run_bit(b, -1, 0, lit_lo(b, 1, lp_mode, lp_period),
                lit_hi(b, 1, lp_mode, lp_period), b, seg[0] ? "R3" : "R2");
      end
    end

    // switch off in the middle of a pulse
    lp_mode = 0; lp_period = 0; loop_en = 0; sir_test = 0;
    uart_tx_bit = 0;
    step(1); step(0); step(0);
    chk(s_ir == 1, "R2", s_ir, 1);
    sir_en = 0;
    step(0); step(0);
    chk(s_ir == 0, "R4", s_ir, 0);
    uart_tx_bit = 1;
    repeat (4) step(0);
    finish_up();
  end

  bit sd_bits_dummy [1];

  initial begin
    repeat (150000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_up();
  end

endmodule